// File: doc/BRIEF.md
# Capacitive Key Baseline Tracker and Touch Detector

This block turns a stream of 16-bit raw capacitive sensing samples into touch decisions for several keys (four by default). Each sample arrives with a valid strobe and a channel index. For every channel the block keeps a baseline level. The baseline creeps toward the raw signal in single-LSB steps. Each step is gated by a prescale counter, and the counter for downward correction runs faster than the one for upward correction. A key is flagged as touched when the signal stays far enough above its baseline for a programmable number of consecutive samples. The flag is released with a hysteresis band. All margins are measured from the baseline, so they move with it.

While a key is touched, its baseline is frozen, so a legitimate touch is not absorbed into the baseline. An optional maximum touch duration can be programmed. When a key stays touched for that many samples, the block recalibrates that channel to the present signal and drops the flag. After reset, each channel's first sample loads its baseline directly. No touch is reported on a channel until that has happened. The baselines are visible on a flat output bus.

Top module: `cap_key_tracker`

## Requirements
- R1: After reset, every key-detect bit is 0, every baseline reads 0, and every channel is uncalibrated.
- R2: The first sample a channel receives after reset copies the raw value into its baseline and never raises that channel's detect bit.
- R3: A sample for channel c changes only channel c's baseline and detect bit. Baseline c sits in bits [16c+15:16c] of `base_flat`, and detect c is bit c of `key_on`.
- R4: A calibrated, idle channel sets its detect bit on the Nth consecutive sample with (raw − baseline) ≥ `thresh`. N is `dwell`, and 0 acts as 1. Any sample with a smaller difference restarts the count.
- R5: A detected channel clears its detect bit on the first sample with (raw − baseline) < `thresh` − `hyst`. Samples at or above that level keep it set.
- R6: The baseline of a channel does not change while its detect bit stays set. It also does not change on a sample that is at or above the threshold.
- R7: On an idle channel with raw above baseline and below threshold, the baseline rises by exactly 1 on every `up_period`-th consecutive such sample. A period of 0 acts as 1.
- R8: On an idle channel with raw below baseline, the baseline falls by exactly 1 on every (`up_period` >> DN_SHIFT)-th consecutive such sample. The minimum is 1, and DN_SHIFT defaults to 2. A change of direction, or a sample equal to the baseline, restarts both drift counts.
- R9: When `max_on` is nonzero and a channel has spent `max_on` samples in detect, that sample loads the baseline with the raw value and clears the detect bit. A `max_on` of 0 disables this.
- R10: The signed difference saturates to 16 bits. A raw value far below the baseline, such as 0 against 60000, never counts toward a detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | CW | Channel index of the sample |
| smp_raw | input | 16 | Raw signal value |
| thresh | input | 16 | Detect threshold above baseline |
| hyst | input | 16 | Hysteresis below threshold for release |
| dwell | input | 4 | Consecutive samples required to enter detect |
| up_period | input | 16 | Samples per upward baseline step |
| max_on | input | 16 | Maximum detect duration in samples, 0 = off |
| key_on | output | NCH | Detect bit per channel |
| base_flat | output | 16*NCH | Baselines, channel c in bits [16c+15:16c] |

## Verification
The bench uses the default four channels and a down-shift of 2. It sets a threshold of 40, a hysteresis of 15, a dwell of 3, an up period of 8 and a maximum touch of 20 samples. With these values, single baseline steps in both directions, the two-sample downward period and the forced recalibration all occur within a few dozen samples. Random offsets of −70 to +90 around the modelled baseline cross both the release level and the threshold often. The wrap-around guard is exercised with baselines near full scale.

// File: rtl/cap_key_tracker.sv
module cap_key_tracker #(
  parameter int NCH      = 4,
  parameter int DN_SHIFT = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CW-1:0]     smp_ch,
  input  logic [15:0]       smp_raw,
  input  logic [15:0]       thresh,
  input  logic [15:0]       hyst,
  input  logic [3:0]        dwell,
  input  logic [15:0]       up_period,
  input  logic [15:0]       max_on,
  output logic [NCH-1:0]    key_on,
  output logic [16*NCH-1:0] base_flat
);

  logic [15:0] base_q [NCH];
  logic [15:0] up_q   [NCH];
  logic [15:0] dn_q   [NCH];
  logic [15:0] on_q   [NCH];
  logic [3:0]  dw_q   [NCH];
  logic [NCH-1:0] det_q, cal_q;

  logic [15:0] b, n_base, n_up, n_dn, n_on;
  logic [3:0]  n_dw;
  logic        n_det;
  logic signed [16:0] dfull;
  logic signed [15:0] dsat;
  logic signed [17:0] dext, thr_lvl, rel_lvl;
  logic [15:0] up_per, dn_per, dn_raw;
  logic [3:0]  nreq;
  logic        above, below;

  assign b       = base_q[smp_ch];
  assign dfull   = $signed({1'b0, smp_raw}) - $signed({1'b0, b});
  assign dsat    = (dfull > 17'sd32767)  ? 16'sh7fff :
                   (dfull < -17'sd32768) ? 16'sh8000 : dfull[15:0];
  assign dext    = {{2{dsat[15]}}, dsat};
  assign thr_lvl = $signed({2'b00, thresh});
  assign rel_lvl = $signed({2'b00, thresh}) - $signed({2'b00, hyst});
  assign above   = dext >= thr_lvl;
  assign below   = dext < rel_lvl;
  assign up_per  = (up_period == 16'd0) ? 16'd1 : up_period;
  assign dn_raw  = up_per >> DN_SHIFT;
  assign dn_per  = (dn_raw == 16'd0) ? 16'd1 : dn_raw;
  assign nreq    = (dwell == 4'd0) ? 4'd1 : dwell;

  always_comb begin
    n_base = b;
    n_up   = up_q[smp_ch];
    n_dn   = dn_q[smp_ch];
    n_on   = on_q[smp_ch];
    n_dw   = dw_q[smp_ch];
    n_det  = det_q[smp_ch];
    if (!cal_q[smp_ch]) begin
      n_base = smp_raw;
      n_det  = 1'b0;
      n_up   = '0;
      n_dn   = '0;
      n_on   = '0;
      n_dw   = '0;
    end else if (det_q[smp_ch]) begin
      n_on = on_q[smp_ch] + 16'd1;
      if (max_on != 16'd0 && ({1'b0, on_q[smp_ch]} + 17'd1) >= {1'b0, max_on}) begin
        n_base = smp_raw;
        n_det  = 1'b0;
        n_on   = '0;
      end else if (below) begin
        n_det = 1'b0;
        n_on  = '0;
      end
    end else if (above) begin
      n_up = '0;
      n_dn = '0;
      if ({1'b0, dw_q[smp_ch]} + 5'd1 >= {1'b0, nreq}) begin
        n_det = 1'b1;
        n_dw  = '0;
        n_on  = '0;
      end else begin
        n_dw = dw_q[smp_ch] + 4'd1;
      end
    end else begin
      n_dw = '0;
      if (smp_raw > b) begin
        n_dn = '0;
        if ({1'b0, up_q[smp_ch]} + 17'd1 >= {1'b0, up_per}) begin
          n_base = b + 16'd1;
          n_up   = '0;
        end else begin
          n_up = up_q[smp_ch] + 16'd1;
        end
      end else if (smp_raw < b) begin
        n_up = '0;
        if ({1'b0, dn_q[smp_ch]} + 17'd1 >= {1'b0, dn_per}) begin
          n_base = b - 16'd1;
          n_dn   = '0;
        end else begin
          n_dn = dn_q[smp_ch] + 16'd1;
        end
      end else begin
        n_up = '0;
        n_dn = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;
      cal_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0;
        up_q[i]   <= '0;
        dn_q[i]   <= '0;
        on_q[i]   <= '0;
        dw_q[i]   <= '0;
      end
    end else if (smp_valid) begin
      base_q[smp_ch] <= n_base;
      up_q[smp_ch]   <= n_up;
      dn_q[smp_ch]   <= n_dn;
      on_q[smp_ch]   <= n_on;
      dw_q[smp_ch]   <= n_dw;
      det_q[smp_ch]  <= n_det;
      cal_q[smp_ch]  <= 1'b1;
    end
  end

  assign key_on = det_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign base_flat[16*c +: 16] = base_q[c];

    AST_NO_DET_UNCAL: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_q[c] |-> !det_q[c]); // R2
    AST_OTHER_CH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_valid && smp_ch == c) |=> $stable(base_q[c]) && $stable(det_q[c])); // R3
    AST_FROZEN_IN_DET: assert property (@(posedge clk) disable iff (!rst_n)
      (det_q[c] && $past(det_q[c])) |-> $stable(base_q[c])); // R6
    AST_SLEW_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_q[c] && !det_q[c]) |=> (base_q[c] == $past(base_q[c]) ||
        base_q[c] == $past(base_q[c]) + 16'd1 || base_q[c] == $past(base_q[c]) - 16'd1)); // R7
  end

endmodule

// File: tb/test_cap_key_tracker.sv
module test_cap_key_tracker;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [CW-1:0] smp_ch = '0;
  logic [15:0] smp_raw = '0;
  logic [15:0] thresh = 16'd40, hyst = 16'd15, up_period = 16'd8, max_on = 16'd20;
  logic [3:0]  dwell = 4'd3;
  logic [NCH-1:0] key_on;
  logic [16*NCH-1:0] base_flat;

  int checks = 0, fails = 0;
  int m_base[NCH], m_up[NCH], m_dn[NCH], m_on[NCH], m_dw[NCH];
  bit m_det[NCH], m_cal[NCH];

  always #10 clk = ~clk;

  cap_key_tracker #(.NCH(NCH), .DN_SHIFT(2)) i_cap_key_tracker (
    .clk, .rst_n, .smp_valid, .smp_ch, .smp_raw, .thresh, .hyst, .dwell,
    .up_period, .max_on, .key_on, .base_flat);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bref(int c);
    return int'(base_flat[16*c +: 16]);
  endfunction

  task automatic model(input int c, input int raw);
    int d, upp, dnp;
    d   = raw - m_base[c];
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    upp = (up_period == 0) ? 1 : int'(up_period);
    dnp = (upp >> 2 == 0) ? 1 : upp >> 2;
    if (!m_cal[c]) begin
      m_base[c] = raw; m_cal[c] = 1; m_det[c] = 0;
      m_up[c] = 0; m_dn[c] = 0; m_on[c] = 0; m_dw[c] = 0;
    end else if (m_det[c]) begin
      m_on[c]++;
      if (max_on != 0 && m_on[c] >= int'(max_on)) begin
        m_base[c] = raw; m_det[c] = 0; m_on[c] = 0;
      end else if (d < int'(thresh) - int'(hyst)) begin
        m_det[c] = 0; m_on[c] = 0;
      end
    end else if (d >= int'(thresh)) begin
      m_up[c] = 0; m_dn[c] = 0; m_dw[c]++;
      if (m_dw[c] >= ((dwell == 0) ? 1 : int'(dwell))) begin
        m_det[c] = 1; m_dw[c] = 0; m_on[c] = 0;
      end
    end else begin
      m_dw[c] = 0;
      if (raw > m_base[c]) begin
        m_dn[c] = 0; m_up[c]++;
        if (m_up[c] >= upp) begin m_base[c]++; m_up[c] = 0; end
      end else if (raw < m_base[c]) begin
        m_up[c] = 0; m_dn[c]++;
        if (m_dn[c] >= dnp) begin m_base[c]--; m_dn[c] = 0; end
      end else begin
        m_up[c] = 0; m_dn[c] = 0;
      end
    end
  endtask

  task automatic samp(input int c, input int raw);
    @(negedge clk);
    smp_valid = 1'b1; smp_ch = CW'(c); smp_raw = 16'(raw);
    model(c, raw);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic cmp_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      check(key_on[c] == m_det[c], tag, int'(key_on[c]), int'(m_det[c]));
      check(bref(c) == m_base[c], tag, bref(c), m_base[c]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_base[c] = 0; m_up[c] = 0; m_dn[c] = 0; m_on[c] = 0; m_dw[c] = 0;
      m_det[c] = 0; m_cal[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(key_on == '0, "R1 reset detect", int'(key_on), 0);
    check(base_flat == '0, "R1 reset baseline", bref(0), 0);

    samp(0, 1000);
    check(bref(0) == 1000 && !key_on[0], "R2 calibration load", bref(0), 1000);
    check(bref(1) == 0, "R3 other channel untouched", bref(1), 0);
    samp(3, 9000);
    check(!key_on[3] && bref(3) == 9000, "R2 no detect on calibration", bref(3), 9000);

    samp(0, 1040); samp(0, 1040); samp(0, 1000);
    samp(0, 1040); samp(0, 1040);
    check(!key_on[0], "R4 count restarted", int'(key_on[0]), 0);
    samp(0, 1040);
    check(key_on[0], "R4 detect on third sample", int'(key_on[0]), 1);
    check(bref(0) == 1000, "R6 no drift on above-threshold samples", bref(0), 1000);
    samp(0, 1026);
    check(key_on[0], "R5 held in hysteresis band", int'(key_on[0]), 1);
    check(bref(0) == 1000, "R6 frozen while detected", bref(0), 1000);
    samp(0, 1024);
    check(!key_on[0], "R5 release below band", int'(key_on[0]), 0);

    for (int i = 0; i < 7; i++) samp(0, 1010);
    check(bref(0) == 1000, "R7 no step before period", bref(0), 1000);
    samp(0, 1010);
    check(bref(0) == 1001, "R7 step at period", bref(0), 1001);
    samp(0, 990);
    check(bref(0) == 1001, "R8 no step before down period", bref(0), 1001);
    samp(0, 990);
    check(bref(0) == 1000, "R8 step at down period", bref(0), 1000);

    samp(1, 500);
    samp(1, 600); samp(1, 600); samp(1, 600);
    check(key_on[1], "R9 detect before timeout", int'(key_on[1]), 1);
    for (int i = 0; i < 19; i++) samp(1, 600);
    check(key_on[1] && bref(1) == 500, "R9 still detected at 19", bref(1), 500);
    samp(1, 600);
    check(!key_on[1], "R9 forced release", int'(key_on[1]), 0);
    check(bref(1) == 600, "R9 forced recalibration", bref(1), 600);

    samp(2, 60000);
    for (int i = 0; i < 5; i++) samp(2, 0);
    check(!key_on[2], "R10 no wrap to touch", int'(key_on[2]), 0);
    check(bref(2) == 59998, "R10 baseline drifts down", bref(2), 59998);
    cmp_all("R3 directed state");

    for (int i = 0; i < 3000; i++) begin
      int c, raw;
      c   = int'($urandom % NCH);
      raw = m_base[c] + int'($urandom % 161) - 70;
      if (raw < 0) raw = 0;
      if (raw > 65535) raw = 65535;
      samp(c, raw);
      cmp_all("R4 R5 R7 R8 random model");
    end
    finish_run();
  end
endmodule